// File: doc/BRIEF.md
# Audio Master and Bit Clock Generator

This block derives the two timing references an audio serial port needs. It runs entirely on the system clock, and every clock it works with is carried as a one-cycle enable pulse on that clock. One of two source enables is picked, either the bus-clock enable or the crystal enable. The picked source is divided down to form the master clock, or an externally supplied master-clock enable from a pin is used in its place. The master clock is divided again to form the bit clock.

Each generated clock is available as a rising-edge enable pulse. The master clock can also be shown as a level on an output pin, which is gated by an output enable. The bit clock is also shown as a level with equal high and low halves.

The divider codes are sampled only at the end of a full output period. A code written part-way through a period therefore never shortens or stretches the period in progress. Until the first period ends after reset, the master divider runs as a pass-through and the bit divider divides by four.

Top module: `audclk_gen`

## Requirements
- R1: `src_sel` picks the source enable: 0 selects `bus_tick` and 1 selects `xtal_tick`.
- R2: With the master divider in pass-through (code 0), every accepted source pulse on cycle c gives `mclk_tick` on cycle c+1. The master level is high for that one cycle only.
- R3: With master code n in 1..7, the master clock has a period of 2n source pulses. Its level rises on the n-th pulse and falls on the 2n-th, one cycle after each pulse. `mclk_tick` marks each rise.
- R4: With bit code n in 0..255, `bclk_lvl` rises after n+1 master pulses and falls after 2n+2 master pulses. `bclk_tick` marks each rise, one cycle after the master pulse that causes it.
- R5: While reset is held, and right after it is released, all outputs are 0. The first master period uses pass-through, and the first bit-clock period divides by 4.
- R6: A divider code is loaded only when a full period of its output ends, which is on the falling transition, or on every pulse in pass-through. A code that changes mid-period leaves the current period unchanged.
- R7: While `mclk_oe` is 0, `mclk_pin` stays 0. While it is 1, `mclk_pin` follows the master level.
- R8: With `mclk_ext` at 1, each `gpio_mclk_tick` pulse on cycle c becomes the master clock: `mclk_tick` and a one-cycle pin level appear on cycle c+1, and the bit divider counts these pulses.
- R9: Pulses on the source that is not selected have no effect on any output. This includes both internal sources while `mclk_ext` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_sel | input | 1 | Source pick: 0 bus-clock enable, 1 crystal enable |
| bus_tick | input | 1 | Bus-clock source enable pulse |
| xtal_tick | input | 1 | Crystal source enable pulse |
| mclk_ext | input | 1 | 1: use the pin-supplied master enable instead of the internal divider |
| gpio_mclk_tick | input | 1 | External master-clock enable pulse |
| mclk_div | input | 3 | Master divider code: 0 pass-through, n divides by 2n |
| bclk_div | input | 8 | Bit divider code: n divides master by 2n+2 |
| mclk_oe | input | 1 | Master-clock pin output enable |
| mclk_tick | output | 1 | Master clock rising-edge enable |
| mclk_pin | output | 1 | Master clock level, gated by `mclk_oe` |
| bclk_tick | output | 1 | Bit clock rising-edge enable |
| bclk_lvl | output | 1 | Bit clock level |

## Verification
The bench changes both divider codes part-way through a period. A design that reloads its codes at once would then move the next edge early or late, and the edge-timing queues would catch it. It also covers the extreme codes: master code 7, bit code 255, and the handover from pass-through to divided mode right after reset. A counter off by one or a wrong reset code would show up as every later edge arriving on the wrong cycle. Pulses are injected on the unselected source, and the pin is kept disabled while the clocks run. A wrong mux or a leaking gate would then produce edges that no queue expects.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  typedef enum logic {SRC_BUS = 1'b0, SRC_XTAL = 1'b1} src_e;
endpackage

// File: rtl/audclk_rst_sync.sv
module audclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/audclk_src_mux.sv
module audclk_src_mux
  import audclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic bus_tick,
  input  logic xtal_tick,
  input  logic gpio_tick,
  output logic int_tick,
  output logic ext_tick_q
);
  logic ext_tick_d;

  always_comb begin
    int_tick   = (src_e'(src_sel) == SRC_XTAL) ? xtal_tick : bus_tick;
    ext_tick_d = gpio_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_tick_q <= 1'b0;
    else        ext_tick_q <= ext_tick_d;
  end
endmodule

// File: rtl/audclk_even_div.sv
module audclk_even_div #(
  parameter int W           = 8,
  parameter bit BYPASS_OK   = 1'b0,
  parameter int RST_HALF_M1 = 0,
  parameter bit RST_BYP     = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_tick,
  input  logic [W-1:0] half_m1_i,
  input  logic         byp_i,
  output logic         tick_o,
  output logic         lvl_o
);
  localparam logic [W-1:0] HALF_RST = W'(RST_HALF_M1);

  logic [W-1:0] cnt_q, cnt_d, half_q, half_d;
  logic         lvl_q, lvl_d, byp_q, byp_d;
  logic         tick_q, tick_d, pls_q, pls_d;
  logic         byp_ok;

  assign byp_ok = byp_i & BYPASS_OK;

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    lvl_d  = lvl_q;
    byp_d  = byp_q;
    tick_d = 1'b0;
    pls_d  = 1'b0;
    if (in_tick) begin
      if (byp_q) begin
        tick_d = 1'b1;
        pls_d  = 1'b1;
        cnt_d  = '0;
        lvl_d  = 1'b0;
        half_d = half_m1_i;
        byp_d  = byp_ok;
      end else if (cnt_q == half_q) begin
        cnt_d = '0;
        lvl_d = ~lvl_q;
        if (!lvl_q) begin
          tick_d = 1'b1;
        end else begin
          half_d = half_m1_i;
          byp_d  = byp_ok;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= HALF_RST;
      lvl_q  <= 1'b0;
      byp_q  <= RST_BYP & BYPASS_OK;
      tick_q <= 1'b0;
      pls_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
      lvl_q  <= lvl_d;
      byp_q  <= byp_d;
      tick_q <= tick_d;
      pls_q  <= pls_d;
    end
  end

  assign tick_o = tick_q;
  assign lvl_o  = lvl_q | pls_q;

  // R2
  tick_after_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(in_tick));

  // R3
  level_moves_on_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(in_tick));

  // R6
  reload_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(half_q) |-> ($fell(lvl_q) || $past(byp_q)));

  // R4
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= half_q);
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen #(
  parameter int MDIV_W   = 3,
  parameter int BDIV_W   = 8,
  parameter int MDIV_RST = 0,
  parameter int BDIV_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_sel,
  input  logic              bus_tick,
  input  logic              xtal_tick,
  input  logic              mclk_ext,
  input  logic              gpio_mclk_tick,
  input  logic [MDIV_W-1:0] mclk_div,
  input  logic [BDIV_W-1:0] bclk_div,
  input  logic              mclk_oe,
  output logic              mclk_tick,
  output logic              mclk_pin,
  output logic              bclk_tick,
  output logic              bclk_lvl
);
  localparam int M_RST_HALF = (MDIV_RST == 0) ? 0 : MDIV_RST - 1;
  localparam bit M_RST_BYP  = (MDIV_RST == 0);
  localparam logic [MDIV_W-1:0] M_ONE = MDIV_W'(1);

  logic rst_ns;
  logic int_tick, ext_tick_q;
  logic mdiv_tick, mdiv_lvl, mclk_lvl;
  logic [MDIV_W-1:0] m_half_m1;
  logic m_byp;

  audclk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_ns)
  );

  audclk_src_mux u_mux (
    .clk(clk), .rst_n(rst_ns), .src_sel(src_sel), .bus_tick(bus_tick),
    .xtal_tick(xtal_tick), .gpio_tick(gpio_mclk_tick),
    .int_tick(int_tick), .ext_tick_q(ext_tick_q)
  );

  always_comb begin
    m_byp     = (mclk_div == '0);
    m_half_m1 = mclk_div - M_ONE;
  end

  audclk_even_div #(
    .W(MDIV_W), .BYPASS_OK(1'b1), .RST_HALF_M1(M_RST_HALF), .RST_BYP(M_RST_BYP)
  ) u_mdiv (
    .clk(clk), .rst_n(rst_ns), .in_tick(int_tick & ~mclk_ext),
    .half_m1_i(m_half_m1), .byp_i(m_byp),
    .tick_o(mdiv_tick), .lvl_o(mdiv_lvl)
  );

  always_comb begin
    mclk_tick = mclk_ext ? ext_tick_q : mdiv_tick;
    mclk_lvl  = mclk_ext ? ext_tick_q : mdiv_lvl;
    mclk_pin  = mclk_oe & mclk_lvl;
  end

  audclk_even_div #(
    .W(BDIV_W), .BYPASS_OK(1'b0), .RST_HALF_M1(BDIV_RST), .RST_BYP(1'b0)
  ) u_bdiv (
    .clk(clk), .rst_n(rst_ns), .in_tick(mclk_tick),
    .half_m1_i(bclk_div), .byp_i(1'b0),
    .tick_o(bclk_tick), .lvl_o(bclk_lvl)
  );

  // R4
  bclk_follows_mclk_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    bclk_tick |-> $past(mclk_tick));

  // R4
  bclk_level_moves_on_mclk_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(bclk_lvl) |-> $past(mclk_tick));
endmodule

// File: tb/audclk_gen_bench.sv
module audclk_gen_bench;
  typedef struct {int cyc; string tag;} ev_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_sel = 1'b0, bus_tick = 1'b0, xtal_tick = 1'b0, mclk_ext = 1'b0;
  logic gpio_mclk_tick = 1'b0, mclk_oe = 1'b1;
  logic [2:0] mclk_div = 3'd0;
  logic [7:0] bclk_div = 8'd1;
  logic mclk_tick, mclk_pin, bclk_tick, bclk_lvl;

  int cyc = 0, n_chk = 0, n_bad = 0;
  bit mon_en = 1'b0, done = 1'b0;
  logic p_pin = 1'b0, p_bl = 1'b0;
  string ph_tag = "R5";
  ev_t q_mt[$], q_mp[$], q_bt[$], q_bl[$];
  int m_h, m_pos, b_h, b_pos;

  audclk_gen u_audclk_gen (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic push(input int which, input int c);
    ev_t e;
    e.cyc = c; e.tag = ph_tag;
    case (which)
      0: q_mt.push_back(e);
      1: q_mp.push_back(e);
      2: q_bt.push_back(e);
      default: q_bl.push_back(e);
    endcase
  endtask

  task automatic take(input int which, input string nm);
    ev_t e;
    int sz;
    case (which)
      0: sz = q_mt.size();
      1: sz = q_mp.size();
      2: sz = q_bt.size();
      default: sz = q_bl.size();
    endcase
    n_chk++;
    if (sz == 0) begin
      n_bad++;
      $display("FAIL %s: %s unexpected event at cycle %0d, expected none", ph_tag, nm, cyc);
    end else begin
      case (which)
        0: e = q_mt.pop_front();
        1: e = q_mp.pop_front();
        2: e = q_bt.pop_front();
        default: e = q_bl.pop_front();
      endcase
      if (e.cyc != cyc) begin
        n_bad++;
        $display("FAIL %s: %s event at cycle %0d, expected %0d", e.tag, nm, cyc, e.cyc);
      end
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    if (mclk_tick) take(0, "mclk_tick");
    if (mclk_pin !== p_pin) take(1, "mclk_pin");
    if (bclk_tick) take(2, "bclk_tick");
    if (bclk_lvl !== p_bl) take(3, "bclk_lvl");
    p_pin = mclk_pin;
    p_bl  = bclk_lvl;
  end

  task automatic check(input string req, input string nm, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: %s got %0d expected %0d", req, nm, act, exp);
    end
  endtask

  // bit clock model: period 2n+2 master pulses, code loaded at period end
  task automatic bstep(input int t);
    b_pos++;
    if (b_pos == b_h) begin push(2, t + 1); push(3, t + 1); end
    if (b_pos == 2 * b_h) begin push(3, t + 1); b_pos = 0; b_h = int'(bclk_div) + 1; end
  endtask

  // master clock model
  task automatic mstep(input int c);
    if (mclk_ext) begin
      push(0, c + 1);
      if (mclk_oe) begin push(1, c + 1); push(1, c + 2); end
      bstep(c + 1);
    end else if (m_h == 0) begin
      push(0, c + 1);
      if (mclk_oe) begin push(1, c + 1); push(1, c + 2); end
      bstep(c + 1);
      m_h = int'(mclk_div); m_pos = 0;
    end else begin
      m_pos++;
      if (m_pos == m_h) begin
        push(0, c + 1);
        if (mclk_oe) push(1, c + 1);
        bstep(c + 1);
      end
      if (m_pos == 2 * m_h) begin
        if (mclk_oe) push(1, c + 1);
        m_pos = 0; m_h = int'(mclk_div);
      end
    end
  endtask

  // driver: ch 0 bus, 1 crystal, 2 pin; caller is at posedge+1
  task automatic tick(input int ch, input int gap);
    bus_tick = (ch == 0); xtal_tick = (ch == 1); gpio_mclk_tick = (ch == 2);
    if (mclk_ext ? (ch == 2) : (ch == int'(src_sel))) mstep(cyc);
    @(posedge clk); #1;
    bus_tick = 1'b0; xtal_tick = 1'b0; gpio_mclk_tick = 1'b0;
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset(input string tag);
    mon_en = 1'b0;
    ph_tag = tag;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R5", "mclk_tick in reset", int'(mclk_tick), 0);
    check("R5", "bclk_lvl in reset", int'(bclk_lvl), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R5", "mclk_pin after reset", int'(mclk_pin), 0);
    check("R5", "bclk_tick after reset", int'(bclk_tick), 0);
    q_mt.delete(); q_mp.delete(); q_bt.delete(); q_bl.delete();
    m_h = 0; m_pos = 0; b_h = 2; b_pos = 0;
    p_pin = 1'b0; p_bl = 1'b0;
    mon_en = 1'b1;
  endtask

  task automatic drain();
    repeat (6) begin @(posedge clk); #1; end
    check(ph_tag, "missed mclk_tick events", q_mt.size(), 0);
    check(ph_tag, "missed mclk_pin events", q_mp.size(), 0);
    check(ph_tag, "missed bclk_tick events", q_bt.size(), 0);
    check(ph_tag, "missed bclk_lvl events", q_bl.size(), 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, expected end before 200000 cycles");
    finish_up();
  end

  initial begin
    // R1 R2 R9: bus source, pass-through, crystal pulses ignored
    src_sel = 1'b0; mclk_div = 3'd0; bclk_div = 8'd1; mclk_oe = 1'b1; mclk_ext = 1'b0;
    do_reset("R1 R2 R9");
    for (int i = 0; i < 16; i++) begin tick(0, 1); tick(1, 1); end
    drain();

    // R1 R3 R6: crystal source back to back, max code, then mid-period changes
    src_sel = 1'b1; mclk_div = 3'd7; bclk_div = 8'd1;
    do_reset("R3 R6");
    for (int i = 0; i < 40; i++) tick(1, 0);
    mclk_div = 3'd3;
    bclk_div = 8'd2;
    for (int i = 0; i < 60; i++) tick(1, 0);
    mclk_div = 3'd1;
    for (int i = 0; i < 30; i++) tick(1, 0);
    drain();

    // R7: pin disabled while clocks run
    src_sel = 1'b0; mclk_div = 3'd2; bclk_div = 8'd0; mclk_oe = 1'b0;
    do_reset("R7");
    for (int i = 0; i < 40; i++) begin
      tick(0, 0);
      if (i % 5 == 4) check("R7", "mclk_pin with output disabled", int'(mclk_pin), 0);
    end
    drain();

    // R8 R9: external master pulses, internal sources ignored
    mclk_oe = 1'b1; mclk_ext = 1'b1; mclk_div = 3'd2; bclk_div = 8'd0; src_sel = 1'b0;
    do_reset("R8 R9");
    for (int i = 0; i < 20; i++) begin tick(2, 1); tick(0, 0); tick(1, 0); end
    drain();

    // R4 R5: reset bit code gives /4 first, then largest code
    mclk_ext = 1'b0; mclk_div = 3'd0; bclk_div = 8'd255; src_sel = 1'b0;
    do_reset("R4 R5");
    for (int i = 0; i < 530; i++) tick(0, 2);
    drain();

    finish_up();
  end
endmodule